// File: doc/BRIEF.md
# Rate-Paced Pin Streaming Engine

This block moves a stream of bytes, halfwords or 32-bit words between one shared memory port and a 32-bit group of I/O pins, through a small FIFO. A phase-accumulator oscillator sets the pace at the pin side. When the engine sends memory to the pins, it prefetches from consecutive addresses whenever the memory port offers a slot. It then emits one FIFO entry to the pins each time the oscillator carries. When it captures pins into memory, the roles reverse. A pin sample is taken on every carry, and samples go to memory whenever a slot is free.

The engine shares the memory port with a processor's ordinary load and store requests. The engine always wins. A processor request goes through only in a slot cycle in which the engine issues nothing. In every other cycle the processor is held by `cpu_stall`. Software starts the engine with a direction, a transfer size and a base address. It stops the engine with a pulse. It can follow burst progress through the live address pointer and through two sticky error flags.

Top module: `stream_fifo_engine`

## Requirements
- R1: After reset `active`, `pin_out`, `pin_strobe`, `underrun`, `overrun`, `cur_ptr` and `mem_req` are all zero.
- R2: With `cfg_dir`=0 (memory to pins), the k-th `pin_strobe` presents the memory word at `cfg_base + k*step`, masked to the transfer size. The size code is 0 for a byte (step 1, mask 0xFF), 1 for a halfword (step 2, mask 0xFFFF) and 2 for a word (step 4, no mask).
- R3: The oscillator adds `nco_incr` to an `ACC_W`-bit accumulator on every active cycle and fires on each carry out. An increment of 2^ACC_W/4 therefore fires exactly once every 4 clocks, and 2^ACC_W fires on every clock.
- R4: While the engine wants the memory port, a processor request is stalled. Starting a memory-to-pins run with an empty FIFO stalls a waiting processor request for exactly DEPTH cycles while the FIFO fills.
- R5: A processor request is granted in a slot cycle in which the engine does not use the port. `mem_addr`/`mem_we` then carry the processor's values, and a read returns `cpu_rvalid` with the memory data one cycle later.
- R6: When `mem_slot` is low, `mem_req` stays low and any processor request is stalled.
- R7: With `cfg_dir`=1 (pins to memory), `pin_in` is sampled on each oscillator fire and marked by `pin_strobe`. Samples are written in order, masked to the size, to `cfg_base + k*step`.
- R8: In memory-to-pins mode, a fire with an empty FIFO sets the sticky `underrun` flag, leaves `pin_out` unchanged and gives no `pin_strobe`.
- R9: In pins-to-memory mode, a fire with a full FIFO drops the sample and sets the sticky `overrun` flag.
- R10: A `stop` pulse clears `active`, discards every FIFO entry without writing it, and zeroes the oscillator phase. After a restart with increment 2^ACC_W/4, the first emission appears on the 4th clock after `start` is taken.
- R11: A `start` pulse loads `cur_ptr` with `cfg_base`, clears both sticky flags and the FIFO, and latches direction and size. `cur_ptr` then advances by one step per engine memory transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse: latch configuration and begin streaming |
| stop | input | 1 | Pulse: halt, flush FIFO, clear phase |
| cfg_dir | input | 1 | 0 = memory to pins, 1 = pins to memory |
| cfg_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| cfg_base | input | AW | First memory address of the stream |
| nco_incr | input | ACC_W+1 | Oscillator phase increment |
| active | output | 1 | Engine running |
| cur_ptr | output | AW | Next memory address the engine will use |
| underrun | output | 1 | Sticky: emission requested with empty FIFO |
| overrun | output | 1 | Sticky: sample dropped on full FIFO |
| pin_in | input | 32 | Pin group sampled in capture mode |
| pin_out | output | 32 | Pin group driven in emit mode |
| pin_strobe | output | 1 | One-cycle mark of a pin transfer |
| cpu_req | input | 1 | Processor memory request |
| cpu_we | input | 1 | Processor write enable |
| cpu_size | input | 2 | Processor transfer size |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_stall | output | 1 | Processor request held this cycle |
| cpu_rdata | output | 32 | Processor read data |
| cpu_rvalid | output | 1 | Processor read data valid |
| mem_slot | input | 1 | Memory port accepts a request this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_size | output | 2 | Memory transfer size |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read request |

## Verification
The bench builds the engine with DEPTH=4, ACC_W=8 and AW=12. A FIFO of four entries fills in a handful of cycles, so the exact stall length at start-up and the drop on a full FIFO are reachable in short directed runs. An 8-bit accumulator makes an increment of 64 fire on every fourth clock and an increment of 256 fire on every clock. That gives both the paced rate check and the fastest-rate underrun and overrun cases. The 12-bit address keeps the memory model a pure function of the address, so every expected pin value and written word is computed from the address alone.

// File: rtl/stream_pkg.sv
// Shared types and helpers for the rate-paced streaming engine.
// Assumes a 32-bit data path; sizes are byte, halfword and word.
package stream_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    // Address increment for one transfer of the given size.
    function automatic logic [2:0] size_step(input xfer_size_e sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Keep only the lanes that belong to the given size.
    function automatic logic [WORD_W-1:0] size_mask(input xfer_size_e sz,
                                                    input logic [WORD_W-1:0] d);
        case (sz)
            SZ_BYTE: return {24'd0, d[7:0]};
            SZ_HALF: return {16'd0, d[15:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/stream_nco.sv
// Phase accumulator that sets the pin transfer pace.
// Fires combinationally in any running cycle whose addition carries out;
// the phase is held at zero while not running. An increment of 2**ACC_W
// fires on every clock.
module stream_nco #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ACC_W:0]   incr,
    output logic             fire
);
    logic [ACC_W-1:0] phase;
    logic [ACC_W:0]   sum;

    // Next phase and carry.
    always_comb begin
        sum  = {1'b0, phase} + incr;
        fire = run && sum[ACC_W];
    end

    // Phase register: cleared whenever the engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else begin
            phase <= sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/stream_fifo.sv
// Circular FIFO of arbitrary depth (not only powers of two).
// Assumes the caller never pushes when full nor pops when empty;
// flush empties it and takes precedence over push and pop.
module stream_fifo #(
    parameter int DEPTH = 19,
    parameter int W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          push,
    input  logic [W-1:0]                  wdata,
    input  logic                          pop,
    output logic [W-1:0]                  rdata,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          full,
    output logic                          empty
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  store [DEPTH];
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] i);
        return (i == IW'(DEPTH-1)) ? '0 : i + 1'b1;
    endfunction

    // Status and head of queue.
    always_comb begin
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
        rdata = store[rd_idx];
    end

    // Entry storage, written on push.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            store[wr_idx] <= wdata;
        end
    end

    // Indices and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (push) wr_idx <= bump(wr_idx);
            if (pop)  rd_idx <= bump(rd_idx);
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/stream_port_arb.sv
// Fixed-priority owner of the single memory port.
// The FIFO side wins any slot it asks for; the processor gets the slot
// only when the FIFO side is quiet. Assumes fifo_req does not depend on
// mem_slot, so no combinational loop forms.
module stream_port_arb #(
    parameter int AW = 20
) (
    input  logic        mem_slot,
    input  logic        fifo_req,
    input  logic        fifo_we,
    input  logic [AW-1:0] fifo_addr,
    input  logic [31:0] fifo_wdata,
    input  logic [1:0]  fifo_size,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    input  logic [1:0]  cpu_size,
    output logic        fifo_grant,
    output logic        cpu_grant,
    output logic        cpu_stall,
    output logic        mem_req,
    output logic        mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [1:0]  mem_size
);
    // Grant decision and port multiplexing.
    always_comb begin
        fifo_grant = mem_slot && fifo_req;
        cpu_grant  = mem_slot && !fifo_req && cpu_req;
        cpu_stall  = cpu_req && !cpu_grant;
        mem_req    = fifo_grant || cpu_grant;
        if (fifo_req) begin
            mem_we    = fifo_grant && fifo_we;
            mem_addr  = fifo_addr;
            mem_wdata = fifo_wdata;
            mem_size  = fifo_size;
        end else begin
            mem_we    = cpu_grant && cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
            mem_size  = cpu_size;
        end
    end
endmodule

// File: rtl/stream_fifo_engine.sv
// Top of the rate-paced streaming engine.
// Memory to pins: prefetch into the FIFO in every won slot, emit one entry
// per oscillator fire. Pins to memory: sample on every fire, write out in
// every won slot. Memory read data is assumed one cycle after the request.
module stream_fifo_engine
    import stream_pkg::*;
#(
    parameter int DEPTH = 19,
    parameter int ACC_W = 16,
    parameter int AW    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             cfg_dir,
    input  logic [1:0]       cfg_size,
    input  logic [AW-1:0]    cfg_base,
    input  logic [ACC_W:0]   nco_incr,
    output logic             active,
    output logic [AW-1:0]    cur_ptr,
    output logic             underrun,
    output logic             overrun,
    input  logic [31:0]      pin_in,
    output logic [31:0]      pin_out,
    output logic             pin_strobe,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [1:0]       cpu_size,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [31:0]      cpu_wdata,
    output logic             cpu_stall,
    output logic [31:0]      cpu_rdata,
    output logic             cpu_rvalid,
    input  logic             mem_slot,
    output logic             mem_req,
    output logic             mem_we,
    output logic [1:0]       mem_size,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata
);
    localparam int CW = $clog2(DEPTH+1);

    logic       dir_r;
    xfer_size_e size_r;
    logic       rd_inflight;
    logic       fire;
    logic       fifo_req;
    logic       fifo_grant;
    logic       cpu_grant;
    logic       f_push, f_pop, f_full, f_empty, f_flush;
    logic [31:0] f_wdata, f_rdata;
    logic [CW-1:0] f_count;
    logic [CW:0]   f_claimed;

    stream_nco #(.ACC_W(ACC_W)) u_nco (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (active),
        .incr (nco_incr),
        .fire (fire)
    );

    stream_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(f_flush),
        .push (f_push),
        .wdata(f_wdata),
        .pop  (f_pop),
        .rdata(f_rdata),
        .count(f_count),
        .full (f_full),
        .empty(f_empty)
    );

    stream_port_arb #(.AW(AW)) u_arb (
        .mem_slot  (mem_slot),
        .fifo_req  (fifo_req),
        .fifo_we   (dir_r),
        .fifo_addr (cur_ptr),
        .fifo_wdata(f_rdata),
        .fifo_size (size_r),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_size  (cpu_size),
        .fifo_grant(fifo_grant),
        .cpu_grant (cpu_grant),
        .cpu_stall (cpu_stall),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_size  (mem_size)
    );

    assign cpu_rdata = mem_rdata;

    // FIFO port demand and push/pop steering for the latched direction.
    always_comb begin
        f_claimed = {1'b0, f_count} + (CW+1)'(rd_inflight);
        f_flush   = start || stop;
        if (!dir_r) begin
            fifo_req = active && (f_claimed < (CW+1)'(DEPTH));
            f_push   = rd_inflight;
            f_wdata  = size_mask(size_r, mem_rdata);
            f_pop    = fire && !f_empty;
        end else begin
            fifo_req = active && !f_empty;
            f_push   = fire && !f_full;
            f_wdata  = size_mask(size_r, pin_in);
            f_pop    = fifo_grant;
        end
    end

    // Run state, latched configuration and address pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            dir_r   <= 1'b0;
            size_r  <= SZ_BYTE;
            cur_ptr <= '0;
        end else if (stop) begin
            active  <= 1'b0;
        end else if (start) begin
            active  <= 1'b1;
            dir_r   <= cfg_dir;
            size_r  <= xfer_size_e'(cfg_size);
            cur_ptr <= cfg_base;
        end else if (fifo_grant) begin
            cur_ptr <= cur_ptr + AW'(size_step(size_r));
        end
    end

    // Outstanding prefetch tracking; dropped on stop or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || start || stop) begin
            rd_inflight <= 1'b0;
        end else begin
            rd_inflight <= fifo_grant && !dir_r;
        end
    end

    // Pin side output register and transfer strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out    <= '0;
            pin_strobe <= 1'b0;
        end else begin
            pin_strobe <= dir_r ? fire : f_pop;
            if (!dir_r && f_pop) begin
                pin_out <= f_rdata;
            end
        end
    end

    // Sticky pacing errors, cleared by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            underrun <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (!dir_r && fire && f_empty) underrun <= 1'b1;
            if (dir_r && fire && f_full)   overrun  <= 1'b1;
        end
    end

    // Processor read data valid one cycle after its grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rvalid <= 1'b0;
        end else begin
            cpu_rvalid <= cpu_grant && !cpu_we;
        end
    end
endmodule

// File: rtl/stream_fifo_engine_chk.sv
// Property checker for the streaming engine, bound to every instance.
// Observes ports plus the port demand and latched size of the engine.
module stream_fifo_engine_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          stop,
    input logic          active,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic          cpu_stall,
    input logic [AW-1:0] cpu_addr,
    input logic          mem_slot,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          fifo_req,
    input logic [1:0]    size_r,
    input logic [AW-1:0] cur_ptr,
    input logic          underrun,
    input logic          overrun,
    input logic [31:0]   pin_out,
    input logic          pin_strobe
);
    logic          past_valid;
    logic [AW-1:0] step_c;

    // Marks cycles that have a defined previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    // Step implied by the latched size.
    always_comb begin
        step_c = (size_r == 2'd0) ? AW'(1) : (size_r == 2'd1) ? AW'(2) : AW'(4);
    end

    AST_CPU_GRANT_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_stall |-> mem_req && mem_addr == cpu_addr && mem_we == cpu_we); // R5
    AST_FIFO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_req && cpu_req |-> cpu_stall); // R4
    AST_NO_SLOT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_slot |-> !mem_req && (!cpu_req || cpu_stall)); // R6
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !active); // R10
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun && !start |=> underrun); // R8
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !start |=> overrun); // R9
    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && !pin_strobe |-> $stable(pin_out)); // R8
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(active) && !$past(start) && !$past(stop)
        && cur_ptr != $past(cur_ptr) |-> cur_ptr == $past(cur_ptr) + step_c); // R11
endmodule

bind stream_fifo_engine stream_fifo_engine_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .active    (active),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_stall (cpu_stall),
    .cpu_addr  (cpu_addr),
    .mem_slot  (mem_slot),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .fifo_req  (fifo_req),
    .size_r    (size_r),
    .cur_ptr   (cur_ptr),
    .underrun  (underrun),
    .overrun   (overrun),
    .pin_out   (pin_out),
    .pin_strobe(pin_strobe)
);

// File: tb/stream_fifo_engine_test.sv
// Directed bench: one task per scenario, each checking its own results.
module stream_fifo_engine_test;
    localparam int DEPTH = 4;
    localparam int ACC_W = 8;
    localparam int AW    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b0, cfg_dir = 1'b0;
    logic [1:0] cfg_size = 2'd0;
    logic [AW-1:0] cfg_base = '0;
    logic [ACC_W:0] nco_incr = '0;
    logic active, underrun, overrun, pin_strobe, cpu_stall, cpu_rvalid;
    logic [AW-1:0] cur_ptr, mem_addr;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, cpu_rdata, mem_wdata;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0] cpu_size = 2'd2;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic mem_slot = 1'b0;
    logic mem_req, mem_we;
    logic [1:0] mem_size;
    logic [31:0] mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int wn = 0;
    logic [AW-1:0] wa [256];
    logic [31:0]   wd [256];

    stream_fifo_engine #(.DEPTH(DEPTH), .ACC_W(ACC_W), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .cfg_dir(cfg_dir), .cfg_size(cfg_size), .cfg_base(cfg_base),
        .nco_incr(nco_incr), .active(active), .cur_ptr(cur_ptr),
        .underrun(underrun), .overrun(overrun), .pin_in(pin_in),
        .pin_out(pin_out), .pin_strobe(pin_strobe), .cpu_req(cpu_req),
        .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall), .cpu_rdata(cpu_rdata),
        .cpu_rvalid(cpu_rvalid), .mem_slot(mem_slot), .mem_req(mem_req),
        .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] mem_val(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] + 8'd1, ~a[7:0], a[7:0]};
    endfunction

    function automatic logic [31:0] lane_mask(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic int step_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    // Memory model: read data one cycle later, writes logged.
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem_val(mem_addr);
        if (mem_req && mem_we) begin
            if (wn < 256) begin
                wa[wn] <= mem_addr;
                wd[wn] <= mem_wdata;
            end
            wn <= wn + 1;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        check(active == 1'b0, "R10 stop clears active", 32'(active), 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(active == 0, "R1 active", 32'(active), 0);
        check(pin_out == 0, "R1 pin_out", pin_out, 0);
        check(pin_strobe == 0, "R1 strobe", 32'(pin_strobe), 0);
        check(underrun == 0 && overrun == 0, "R1 flags", {30'd0, underrun, overrun}, 0);
        check(cur_ptr == 0, "R1 cur_ptr", 32'(cur_ptr), 0);
        check(mem_req == 0, "R1 mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_cpu_idle();
        int w0;
        mem_slot = 1'b1; cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 12'h044;
        #1;
        check(!cpu_stall && mem_req && mem_addr == 12'h044, "R5 idle read granted",
              {cpu_stall, mem_req, 18'd0, mem_addr}, {2'b01, 18'd0, 12'h044});
        @(negedge clk);
        check(cpu_rvalid && cpu_rdata == mem_val(12'h044), "R5 read data", cpu_rdata,
              mem_val(12'h044));
        w0 = wn;
        cpu_we = 1'b1; cpu_addr = 12'h050; cpu_wdata = 32'hCAFE_0123;
        @(negedge clk);
        check(wn == w0 + 1 && wa[w0] == 12'h050 && wd[w0] == 32'hCAFE_0123,
              "R5 idle write", wd[w0], 32'hCAFE_0123);
        mem_slot = 1'b0; cpu_we = 1'b0;
        #1;
        check(cpu_stall && !mem_req, "R6 no slot stalls", {30'd0, cpu_stall, mem_req}, 32'd2);
        @(negedge clk) cpu_req = 1'b0;
    endtask

    task automatic t_m2p(input logic [1:0] sz, input logic [AW-1:0] base);
        int k = 0;
        int guard = 0;
        int cnt = 0;
        logic [31:0] exp;
        mem_slot = 1'b1; cfg_dir = 1'b0; cfg_size = sz; cfg_base = base;
        nco_incr = 9'd64;
        pulse_start();
        while (k < 6 && guard < 200) begin
            @(negedge clk);
            guard++;
            if (pin_strobe) begin
                exp = mem_val(base + AW'(k * step_of(sz))) & lane_mask(sz);
                check(pin_out == exp, "R2 emitted value", pin_out, exp);
                k++;
            end
        end
        check(k == 6, "R2 emissions seen", 32'(k), 32'd6);
        repeat (40) begin
            @(negedge clk);
            if (pin_strobe) cnt++;
        end
        check(cnt == 10, "R3 paced rate", 32'(cnt), 32'd10);
        check(underrun == 0, "R8 no underrun when fed", 32'(underrun), 0);
        pulse_stop();
    endtask

    task automatic t_priority();
        int stalls = 0;
        mem_slot = 1'b1; cfg_dir = 1'b0; cfg_size = 2'd2; cfg_base = 12'h200;
        nco_incr = 9'd1;
        pulse_start();
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 12'h3C0;
        #1;
        while (cpu_stall && stalls < 50) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        check(stalls == DEPTH, "R4 stall cycles during fill", 32'(stalls), 32'(DEPTH));
        check(mem_addr == 12'h3C0 && !mem_we, "R5 grant after fill", 32'(mem_addr), 32'h3C0);
        @(negedge clk);
        check(cpu_rvalid && cpu_rdata == mem_val(12'h3C0), "R5 read after fill",
              cpu_rdata, mem_val(12'h3C0));
        cpu_req = 1'b0;
        pulse_stop();
    endtask

    task automatic t_underrun();
        int seen = 0;
        logic [31:0] prev;
        prev = pin_out;
        mem_slot = 1'b0; cfg_dir = 1'b0; cfg_size = 2'd2; nco_incr = 9'd256;
        pulse_start();
        check(underrun == 0, "R11 start clears underrun", 32'(underrun), 0);
        repeat (6) begin
            @(negedge clk);
            if (pin_strobe) seen++;
        end
        check(underrun == 1, "R8 underrun set", 32'(underrun), 1);
        check(seen == 0, "R8 no strobe on underrun", 32'(seen), 0);
        check(pin_out == prev, "R8 output held", pin_out, prev);
        pulse_stop();
        check(underrun == 1, "R8 underrun sticky after stop", 32'(underrun), 1);
    endtask

    task automatic t_p2m();
        int k = 0;
        int guard = 0;
        int w0;
        logic [31:0] exp;
        w0 = wn;
        mem_slot = 1'b1; cfg_dir = 1'b1; cfg_size = 2'd1; cfg_base = 12'h100;
        nco_incr = 9'd64;
        pin_in = 32'hBEEF_0005;
        pulse_start();
        while (k < 5 && guard < 200) begin
            @(negedge clk);
            guard++;
            if (pin_strobe) begin
                k++;
                pin_in = 32'hBEEF_0000 | 32'(k * 37 + 5);
            end
        end
        repeat (3) @(negedge clk);
        check(wn - w0 == 5, "R7 write count", 32'(wn - w0), 32'd5);
        for (int i = 0; i < 5; i++) begin
            exp = 32'(i * 37 + 5);
            check(wd[w0+i] == exp && wa[w0+i] == 12'h100 + AW'(2 * i), "R7 captured word",
                  wd[w0+i], exp);
        end
        check(cur_ptr == 12'h10A, "R11 progress pointer", 32'(cur_ptr), 32'h10A);
        check(overrun == 0, "R9 no overrun when drained", 32'(overrun), 0);
        pulse_stop();
    endtask

    task automatic t_overrun_flush();
        int w0;
        w0 = wn;
        mem_slot = 1'b0; cfg_dir = 1'b1; cfg_size = 2'd2; cfg_base = 12'h300;
        nco_incr = 9'd256; pin_in = 32'h1234_5678;
        pulse_start();
        repeat (8) @(negedge clk);
        check(overrun == 1, "R9 overrun set", 32'(overrun), 1);
        check(wn == w0, "R6 nothing written without slot", 32'(wn - w0), 0);
        pulse_stop();
        mem_slot = 1'b1;
        repeat (6) @(negedge clk);
        check(wn == w0, "R10 stop discards queued samples", 32'(wn - w0), 0);
        mem_slot = 1'b0;
        pulse_start();
        check(overrun == 0, "R11 start clears overrun", 32'(overrun), 0);
        pulse_stop();
    endtask

    task automatic t_phase_restart();
        int k = 0;
        mem_slot = 1'b1; cfg_dir = 1'b0; cfg_size = 2'd0; cfg_base = 12'h020;
        nco_incr = 9'd64;
        pulse_start();
        repeat (6) @(negedge clk);
        pulse_stop();
        pulse_start();
        check(cur_ptr == 12'h020, "R11 pointer reloaded", 32'(cur_ptr), 32'h020);
        while (k < 20) begin
            @(negedge clk);
            k++;
            if (pin_strobe) break;
        end
        check(k == 4, "R10 phase cleared on stop", 32'(k), 32'd4);
        check(pin_out == (mem_val(12'h020) & 32'hFF), "R10 restart from base", pin_out,
              mem_val(12'h020) & 32'hFF);
        pulse_stop();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_cpu_idle();
        t_m2p(2'd0, 12'h010);
        t_m2p(2'd1, 12'h080);
        t_m2p(2'd2, 12'h0C0);
        t_priority();
        t_underrun();
        t_p2m();
        t_overrun_flush();
        t_phase_restart();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule